// File: doc/BRIEF.md
# Elastic Bit Store with Stuff Request Control

This block absorbs the jitter and small rate differences between an incoming serial bit stream and a local read timing. Each incoming bit is written into a sixteen-entry bit store when its conditioned timing strobe arrives. Each gated clock from the local clock generator reads one stored bit back out. The write address lives in the write clock domain. It crosses into the read domain as a Gray code, so the read side can measure how far apart the two addresses are.

The control logic keeps the distance between the two addresses near half the store depth. If the read side falls too far behind, it asks for a positive stuff, which means one extra gated clock. If the read side creeps too close to the writer, it asks for a negative stuff, which means one gated clock fewer. A request stays raised until the distance is back on target. A mode input selects how gated clocks reach the read counter. In direct mode every gated clock advances it. In conversion mode a deletion stage drops one gated clock out of every fixed group, which lowers the effective read rate.

The external clock generator acts on the requests. The block only raises them.

Top module: `elastic_stuff_store`

## Requirements
- R1: While rst_n is low at a clock edge, wr_addr, rd_addr, rd_bit, stuff_pos and stuff_neg are all driven to 0.
- R2: Each wr_clk edge with wr_en high stores wr_bit at address wr_addr and advances wr_addr by one, wrapping modulo 16.
- R3: In direct mode (conv_mode = 0), each rd_clk edge with gclk_en high advances rd_addr by one, modulo 16. The same edge loads rd_bit with the bit stored at the old rd_addr, so bits leave in the order they were written. The distance is (write address seen in the read domain minus rd_addr) mod 16. When one write and one read happen on every edge, this distance stays fixed.
- R4: stuff_pos rises once that distance exceeds 8 + OFFSET (default 11 or more). A distance of exactly 10 does not raise it. The flag appears three rd_clk edges after the write edge that caused it.
- R5: stuff_neg rises once that distance falls below 8 − OFFSET (default 5 or less), one rd_clk edge after the read that caused it. It also rises right after reset, because the store is then empty.
- R6: A raised request stays high at intermediate distances, such as 9 or 10 for stuff_pos and 6 or 7 for stuff_neg. It clears only when the distance equals exactly 8.
- R7: stuff_pos and stuff_neg are never high together.
- R8: In conversion mode (conv_mode = 1), the deletion stage counts gated clocks from the moment the mode was entered. Every DEL_PERIOD-th gated clock (default every 4th) is dropped. rd_addr and rd_bit do not change on a dropped clock. Leaving conversion mode restarts the count.
- R9: An rd_clk edge with gclk_en low leaves rd_addr and rd_bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, applied to both domains |
| wr_en | input | 1 | Conditioned input timing strobe, one per incoming bit |
| wr_bit | input | 1 | Incoming data bit |
| gclk_en | input | 1 | Gated clock pulse from the local clock generator |
| conv_mode | input | 1 | 0 = direct read clocking, 1 = clock-deletion path |
| rd_bit | output | 1 | Bit read from the store |
| rd_addr | output | 4 | Read address count |
| wr_addr | output | 4 | Write address count |
| stuff_pos | output | 1 | Request for one extra gated clock |
| stuff_neg | output | 1 | Request for one fewer gated clock |

## Verification
The results are due at different times. rd_addr and rd_bit change on the same rd_clk edge that carries an accepted gated clock. A request caused by a read shows up one edge later. A request caused by a write waits three read edges, because the write address passes through a two-stage synchronizer and then the request register.

The bench drives inputs and samples outputs on falling edges. After every move that changes the distance, it idles five cycles before it reads the request flags, which covers the longest of these paths. It checks rd_bit in the half cycle right after each gated clock, using its own model of the store contents and of the deletion count.

// File: rtl/es_pkg.sv
// Package for the elastic store: shared state type of the stuff controller.
// Assumes nothing beyond the 1800-2017 language.
package es_pkg;

    // Tracking state of the address separation monitor
    typedef enum logic [1:0] {
        SEP_TRACK = 2'd0,
        SEP_POS   = 2'd1,
        SEP_NEG   = 2'd2
    } sep_state_e;

endpackage

// File: rtl/es_write_side.sv
// Write side: binary write counter, Gray copy of the counter for the
// crossing, and the bit store itself. Assumes wr_en is one strobe per bit,
// already conditioned to wr_clk.
module es_write_side #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] wr_gray,
    output logic [DEPTH-1:0]  store
);

    logic [ADDR_W-1:0] addr_nxt;

    // Next write address, used for both binary and Gray registers
    always_comb begin
        addr_nxt = wr_addr + 1'b1;
    end

    // Store the bit and advance both counter forms on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_gray <= '0;
            store   <= '0;
        end else if (wr_en) begin
            store[wr_addr] <= wr_bit;
            wr_addr        <= addr_nxt;
            wr_gray        <= addr_nxt ^ (addr_nxt >> 1);
        end
    end

endmodule

// File: rtl/es_gray_sync.sv
// Carries a Gray-coded count into another clock domain through a chain of
// flops and converts it back to binary. Assumes the source changes by at
// most one code step per source clock.
module es_gray_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] chain [STAGES];

    // Synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= gray_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    // Gray to binary conversion of the last stage
    always_comb begin
        bin_out[W-1] = chain[STAGES-1][W-1];
        for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ chain[STAGES-1][i];
    end

endmodule

// File: rtl/es_read_side.sv
// Read side: optional gated clock deletion stage, read address counter and
// output bit register. Assumes gclk_en is one pulse per gated clock in the
// rd_clk domain.
module es_read_side #(
    parameter int ADDR_W     = 4,
    parameter int DEL_PERIOD = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gclk_en,
    input  logic              conv_mode,
    input  logic [DEPTH-1:0]  store,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit,
    output logic              rd_step
);

    logic drop;

    generate
        if (DEL_PERIOD > 1) begin : g_del
            localparam int CW = $clog2(DEL_PERIOD);
            localparam logic [CW-1:0] LAST = CW'(DEL_PERIOD - 1);
            logic [CW-1:0] del_cnt;

            // Count gated clocks while in conversion mode
            always_ff @(posedge clk) begin
                if (!rst_n || !conv_mode) begin
                    del_cnt <= '0;
                end else if (gclk_en) begin
                    del_cnt <= (del_cnt == LAST) ? '0 : del_cnt + 1'b1;
                end
            end

            // Drop the last gated clock of each group
            always_comb begin
                drop = conv_mode && (del_cnt == LAST);
            end
        end else begin : g_nodel
            // No deletion configured
            always_comb begin
                drop = 1'b0;
            end
        end
    endgenerate

    // Accepted read clock
    always_comb begin
        rd_step = gclk_en && !drop;
    end

    // Read one bit and advance the read address per accepted clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
            rd_bit  <= 1'b0;
        end else if (rd_step) begin
            rd_bit  <= store[rd_addr];
            rd_addr <= rd_addr + 1'b1;
        end
    end

endmodule

// File: rtl/es_stuff_ctrl.sv
// Separation monitor: compares the synchronized write address with the read
// address and holds a positive or negative stuff request until the
// separation returns to half the store depth. Assumes the separation moves
// by at most one count per clock.
module es_stuff_ctrl
    import es_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int OFFSET = 2,
    localparam int TARGET = (1 << ADDR_W) / 2,
    localparam int HI     = TARGET + OFFSET,
    localparam int LO     = TARGET - OFFSET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sep,
    output logic              stuff_pos,
    output logic              stuff_neg
);

    sep_state_e state_q, state_d;

    // Decide the next request state from the current separation
    always_comb begin
        if (int'(sep) > HI)          state_d = SEP_POS;
        else if (int'(sep) < LO)     state_d = SEP_NEG;
        else if (int'(sep) == TARGET) state_d = SEP_TRACK;
        else                         state_d = state_q;
    end

    // Request state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEP_TRACK;
        else        state_q <= state_d;
    end

    // Request outputs
    always_comb begin
        stuff_pos = (state_q == SEP_POS);
        stuff_neg = (state_q == SEP_NEG);
    end

endmodule

// File: rtl/elastic_stuff_store.sv
// Top: elastic bit store with stuff request control. Write side in wr_clk,
// read side and separation monitor in rd_clk, write count crossing as Gray.
// Assumes rst_n is synchronous to both clocks and held for several cycles.
module elastic_stuff_store #(
    parameter int ADDR_W      = 4,
    parameter int OFFSET      = 2,
    parameter int DEL_PERIOD  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic              gclk_en,
    input  logic              conv_mode,
    output logic              rd_bit,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              stuff_pos,
    output logic              stuff_neg
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] wr_gray;
    logic [ADDR_W-1:0] wr_seen;
    logic [ADDR_W-1:0] sep;
    logic [DEPTH-1:0]  store;
    logic              rd_step;

    es_write_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bit  (wr_bit),
        .wr_addr (wr_addr),
        .wr_gray (wr_gray),
        .store   (store)
    );

    es_gray_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .gray_in (wr_gray),
        .bin_out (wr_seen)
    );

    es_read_side #(.ADDR_W(ADDR_W), .DEL_PERIOD(DEL_PERIOD)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .gclk_en   (gclk_en),
        .conv_mode (conv_mode),
        .store     (store),
        .rd_addr   (rd_addr),
        .rd_bit    (rd_bit),
        .rd_step   (rd_step)
    );

    // Separation of write and read addresses, modulo the store depth
    always_comb begin
        sep = wr_seen - rd_addr;
    end

    es_stuff_ctrl #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_ctl (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .sep       (sep),
        .stuff_pos (stuff_pos),
        .stuff_neg (stuff_neg)
    );

endmodule

// File: rtl/es_checker.sv
// Property checker for the elastic store, bound to the top module.
module es_checker #(
    parameter int ADDR_W = 4,
    parameter int OFFSET = 2,
    localparam int TARGET = (1 << ADDR_W) / 2
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              gclk_en,
    input logic              conv_mode,
    input logic              rd_step,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] sep,
    input logic              stuff_pos,
    input logic              stuff_neg
);

    p_wr_step_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_en |=> wr_addr == ADDR_W'($past(wr_addr) + 1));

    p_direct_step_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!conv_mode && gclk_en) |=> rd_addr == ADDR_W'($past(rd_addr) + 1));

    p_pos_raise_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (int'(sep) > TARGET + OFFSET) |=> stuff_pos);

    p_neg_raise_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (int'(sep) < TARGET - OFFSET) |=> stuff_neg);

    p_pos_release_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $fell(stuff_pos) |-> (int'($past(sep)) == TARGET || int'($past(sep)) < TARGET - OFFSET));

    p_exclusive_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !(stuff_pos && stuff_neg));

    p_no_added_clock_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_step |-> gclk_en);

    p_idle_hold_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !gclk_en |=> $stable(rd_addr));

endmodule

bind elastic_stuff_store es_checker #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .gclk_en   (gclk_en),
    .conv_mode (conv_mode),
    .rd_step   (rd_step),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .sep       (sep),
    .stuff_pos (stuff_pos),
    .stuff_neg (stuff_neg)
);

// File: tb/elastic_stuff_store_test.sv
module elastic_stuff_store_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_bit = 1'b0;
    logic       gclk_en = 1'b0;
    logic       conv_mode = 1'b0;
    logic       rd_bit;
    logic [3:0] rd_addr;
    logic [3:0] wr_addr;
    logic       stuff_pos;
    logic       stuff_neg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model
    logic model [16];
    int   wp = 0;
    int   rp = 0;
    int   dcnt = 0;
    logic last_bit = 1'b0;

    always #10 clk = ~clk;

    elastic_stuff_store uut (
        .wr_clk    (clk),
        .rd_clk    (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bit    (wr_bit),
        .gclk_en   (gclk_en),
        .conv_mode (conv_mode),
        .rd_bit    (rd_bit),
        .rd_addr   (rd_addr),
        .wr_addr   (wr_addr),
        .stuff_pos (stuff_pos),
        .stuff_neg (stuff_neg)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pattern(input int n);
        logic [3:0] v;
        v = 4'(n * 5 + 3);
        return v[0] ^ v[2] ^ v[3] ^ n[4];
    endfunction

    // One clock: optional write and optional gated clock; checks read result
    task automatic step(input logic w, input logic r);
        logic pass;
        logic expb;
        wr_en   = w;
        wr_bit  = pattern(wp);
        gclk_en = r;
        pass = r && !(conv_mode && dcnt == 3);
        expb = pass ? model[rp % 16] : last_bit;
        @(posedge clk);
        @(negedge clk);
        if (w) begin
            model[wp % 16] = wr_bit;
            wp++;
        end
        if (r && conv_mode) dcnt = (dcnt == 3) ? 0 : dcnt + 1;
        if (!conv_mode) dcnt = 0;
        if (pass) rp++;
        last_bit = expb;
        wr_en = 1'b0;
        gclk_en = 1'b0;
        if (r) begin
            chk(conv_mode ? "R8 rd_bit" : "R3 rd_bit", int'(rd_bit), int'(expb));
            chk(conv_mode ? "R8 rd_addr" : "R3 rd_addr", int'(rd_addr), rp % 16);
        end
        if (w) chk("R2 wr_addr", int'(wr_addr), wp % 16);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic flags(input string req, input int ep, input int en);
        chk({req, " stuff_pos"}, int'(stuff_pos), ep);
        chk({req, " stuff_neg"}, int'(stuff_neg), en);
        chk("R7 exclusive", int'(stuff_pos && stuff_neg), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rd_addr", int'(rd_addr), 0);
        chk("R1 wr_addr", int'(wr_addr), 0);
        chk("R1 rd_bit", int'(rd_bit), 0);
        flags("R1", 0, 0);
        rst_n = 1'b1;
        settle();
        flags("R5 empty after reset", 0, 1);
    endtask

    task automatic t_fill_neg_release();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        settle();
        flags("R5 sep5", 0, 1);
        step(1'b1, 1'b0);
        settle();
        flags("R6 sep6 hold", 0, 1);
        step(1'b1, 1'b0);
        settle();
        flags("R6 sep7 hold", 0, 1);
        step(1'b1, 1'b0);
        settle();
        flags("R6 sep8 clear", 0, 0);
    endtask

    task automatic t_pos_raise_hold();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        settle();
        flags("R4 sep10 below", 0, 0);
        step(1'b1, 1'b0);
        settle();
        flags("R4 sep11", 1, 0);
        step(1'b0, 1'b1);
        settle();
        flags("R6 sep10 hold", 1, 0);
        step(1'b0, 1'b1);
        settle();
        flags("R6 sep9 hold", 1, 0);
        step(1'b0, 1'b1);
        settle();
        flags("R6 sep8 clear", 0, 0);
    endtask

    task automatic t_lockstep();
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
        settle();
        flags("R3 lockstep", 0, 0);
    endtask

    task automatic t_idle();
        logic [3:0] a;
        logic b;
        a = rd_addr;
        b = rd_bit;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        chk("R9 rd_addr idle", int'(rd_addr), int'(a));
        chk("R9 rd_bit idle", int'(rd_bit), int'(b));
    endtask

    task automatic t_neg_by_reads();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        settle();
        flags("R5 sep5 by reads", 0, 1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        settle();
        flags("R6 back to 8", 0, 0);
    endtask

    task automatic t_conversion();
        int start;
        conv_mode = 1'b1;
        @(negedge clk);
        start = rp;
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1);
        chk("R8 reads accepted", rp - start, 6);
        chk("R8 rd_addr after 8 clocks", int'(rd_addr), rp % 16);
        settle();
        flags("R4 sep10 in conversion", 0, 0);
        conv_mode = 1'b0;
        @(negedge clk);
        dcnt = 0;
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        settle();
        flags("R6 direct again sep8", 0, 0);
        conv_mode = 1'b1;
        @(negedge clk);
        start = rp;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
        chk("R8 restart after mode exit", rp - start, 3);
        conv_mode = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_neg_release();
        t_pos_raise_hold();
        t_lockstep();
        t_idle();
        t_neg_by_reads();
        t_conversion();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule